// File: doc/BRIEF.md
# Configuration Register Software-Access Detector

This block watches the decoded, clocked access stream of a pseudo-SRAM model for a fixed four-access sequence aimed at the top word of the address space. The sequence lets software reach the device configuration register through ordinary reads and writes. A sequence that ends in a write loads the register. A sequence that ends in a read returns the register contents in place of array data. While the sequence runs, the block keeps the array word at the top address unchanged, because it suppresses the array writes that belong to the sequence.

Each access arrives as a one-cycle strobe with an address, a write flag and write data. The block answers in the same cycle with a read-override flag and the data to return, and with a write-block flag for the array. One cycle after a completed load it raises a one-cycle pulse, which tells the sleep controller that a software load has happened and that the sleep pin no longer starts partial-array refresh. It also presents the current register value.

Top module: `cfgreg_seq_detect`

## Requirements
- R1: After reset the register reads 0x0010, and the read-override, write-block and load-pulse outputs are low.
- R2: A load sequence (read, read, write of 0x0000, write of a value, all at the top address 0x7FFFF) stores the value with bits 3 and 15:8 forced to 0. Bits 2:0 (partial-array region), 6:5 (refresh temperature, 00 selecting the internal sensor) and 7 (page mode) are taken as written. The new value is visible one cycle after the fourth write.
- R3: The load pulse is high for exactly the one cycle that follows the fourth write of a load. A read sequence never raises it.
- R4: In a read sequence (read, read, write of 0x0000, read, all at the top address), the fourth read raises read-override in the same cycle, with read data equal to the register. The register is unchanged.
- R5: Write-block is high in the same cycle as the zero write at step 3 and as the step-4 write. It stays low for every other write, including a step-3 write of nonzero data.
- R6: A third consecutive read of the top address cancels recognition. Accesses to the top address do not complete a sequence until a read of another address is seen.
- R7: A write to another address does not end the cancelled condition.
- R8: Outside the cancelled condition, an access to another address, or a step that does not match (a write at step 1 or 2, or a nonzero write at step 3), returns the recognizer to idle.
- R9: A software load whose bit 4 (sleep mode) is 0 leaves bit 4 at its previous value. A load whose bit 4 is 1 stores 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_addr | input | ADDR_W (19) | Access word address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | DATA_W (16) | Write data |
| cfg_value | output | DATA_W (16) | Current register contents |
| rd_override | output | 1 | Current read returns register data instead of array data |
| rd_data | output | DATA_W (16) | Data to return while rd_override is high |
| wr_block | output | 1 | Current write must not reach the array |
| sw_load | output | 1 | One-cycle pulse after a software load |

## Verification
The hardest state to reach is the cancelled condition, and in particular leaving it. The stimulus reaches it with three top-address reads in a row. It then tries to complete both a load and a read while cancelled, and it inserts a write to another address to show that this write does not clear the condition. Only after a read of another address does a full sequence run again, and the checks confirm that it completes. Broken sequences, such as a nonzero step-3 write or a foreign read between steps, are followed by the access that would have finished a sequence, so that a recognizer which failed to reset shows up on the override and block outputs.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_RD1  = 3'd1,
        SQ_RD2  = 3'd2,
        SQ_ZW   = 3'd3,
        SQ_HOLD = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
    } fsm_regs_t;

endpackage

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
    import cfgseq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              do_load,
    output logic              do_read,
    output logic              blk
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    fsm_regs_t r_q, r_d;
    logic is_top, is_zero;

    always_comb begin
        is_top  = (acc_addr == TOP_ADDR);
        is_zero = (acc_wdata == '0);
        r_d     = r_q;
        do_load = 1'b0;
        do_read = 1'b0;
        blk     = 1'b0;
        if (acc_valid) begin
            if (!is_top) begin
                if (!acc_write || r_q.st != SQ_HOLD)
                    r_d.st = SQ_IDLE;
            end else begin
                unique case (r_q.st)
                    SQ_IDLE: r_d.st = acc_write ? SQ_IDLE : SQ_RD1;
                    SQ_RD1:  r_d.st = acc_write ? SQ_IDLE : SQ_RD2;
                    SQ_RD2: begin
                        if (!acc_write) begin
                            r_d.st = SQ_HOLD;
                        end else if (is_zero) begin
                            r_d.st = SQ_ZW;
                            blk    = 1'b1;
                        end else begin
                            r_d.st = SQ_IDLE;
                        end
                    end
                    SQ_ZW: begin
                        r_d.st  = SQ_IDLE;
                        do_load = acc_write;
                        do_read = !acc_write;
                        blk     = acc_write;
                    end
                    SQ_HOLD: r_d.st = SQ_HOLD;
                    default: r_d.st = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.st <= SQ_IDLE;
        else        r_q    <= r_d;
    end
endmodule

// File: rtl/cfgseq_regfile.sv
module cfgseq_regfile #(
    parameter int                DATA_W    = 16,
    parameter int                RSVD_BIT  = 3,
    parameter int                SLEEP_BIT = 4,
    parameter int                TOP_FIELD = 7,
    parameter logic [DATA_W-1:0] CFG_INIT  = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] cfg_q_o,
    output logic              pulse_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic              pulse;
    } reg_t;

    reg_t r_q, r_d;
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] masked;

    for (genvar i = 0; i < DATA_W; i++) begin : g_keep
        assign keep[i] = (i <= TOP_FIELD) && (i != RSVD_BIT);
    end

    always_comb begin
        r_d       = r_q;
        r_d.pulse = do_load;
        masked    = load_val & keep;
        if (do_load) begin
            r_d.cfg            = masked;
            r_d.cfg[SLEEP_BIT] = masked[SLEEP_BIT] | r_q.cfg[SLEEP_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.cfg   <= CFG_INIT;
            r_q.pulse <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_q_o = r_q.cfg;
    assign pulse_o = r_q.pulse;
endmodule

// File: rtl/cfgreg_seq_detect.sv
module cfgreg_seq_detect #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] cfg_value,
    output logic              rd_override,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_block,
    output logic              sw_load
);
    logic do_load, do_read, blk;

    cfgseq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_wdata(acc_wdata),
        .do_load(do_load), .do_read(do_read), .blk(blk)
    );

    cfgseq_regfile #(.DATA_W(DATA_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .do_load(do_load), .load_val(acc_wdata),
        .cfg_q_o(cfg_value), .pulse_o(sw_load)
    );

    assign rd_override = do_read;
    assign rd_data     = do_read ? cfg_value : '0;
    assign wr_block    = blk;
endmodule

// File: rtl/cfgseq_chk.sv
module cfgseq_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic [DATA_W-1:0] cfg_value,
    input logic              rd_override,
    input logic              wr_block,
    input logic              sw_load
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [DATA_W-1:0] RSVD_MASK = ~DATA_W'(16'h00F7);

    p_override_on_top_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_override |-> (acc_valid && !acc_write && acc_addr == TOP_ADDR));

    p_block_on_top_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |-> (acc_valid && acc_write && acc_addr == TOP_ADDR));

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_load |=> !sw_load);

    p_cfg_moves_with_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_value) |-> sw_load);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_value & RSVD_MASK) == '0);

    p_sleep_not_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cfg_value[4]));
endmodule

bind cfgreg_seq_detect cfgseq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .cfg_value(cfg_value), .rd_override(rd_override),
    .wr_block(wr_block), .sw_load(sw_load)
);

// File: tb/sim_cfgreg_seq_detect.sv
`timescale 1ns/1ps
module sim_cfgreg_seq_detect;
    localparam int AW = 19;
    localparam int DW = 16;
    localparam logic [AW-1:0] TOPA = 19'h7FFFF;
    localparam logic [AW-1:0] OTHA = 19'h00123;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic acc_write = 1'b0;
    logic [DW-1:0] acc_wdata = '0;
    logic [DW-1:0] cfg_value, rd_data;
    logic rd_override, wr_block, sw_load;

    int errors = 0;
    int checks = 0;
    logic ovr_s, blk_s, pulse_s;
    logic [DW-1:0] rd_s, cfg_s;
    logic [DW-1:0] exp_cfg;

    always #10 clk = ~clk;

    cfgreg_seq_detect #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_wdata(acc_wdata), .cfg_value(cfg_value),
        .rd_override(rd_override), .rd_data(rd_data), .wr_block(wr_block),
        .sw_load(sw_load)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_wdata = d;
        #5;
        ovr_s = rd_override; blk_s = wr_block; rd_s = rd_data;
        @(negedge clk);
        acc_valid = 1'b0;
        pulse_s = sw_load; cfg_s = cfg_value;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 cfg", 32'(cfg_value), 32'h0010);
        chk("R1 flags", {29'd0, rd_override, wr_block, sw_load}, 32'd0);
    endtask

    task automatic t_load(input logic [DW-1:0] v, input logic [DW-1:0] expv);
        acc(TOPA, 1'b0, '0); chk("R5 read not blocked", 32'(blk_s), 32'd0);
        acc(TOPA, 1'b0, '0);
        acc(TOPA, 1'b1, 16'h0000); chk("R5 step3 blocked", 32'(blk_s), 32'd1);
        acc(TOPA, 1'b1, v);
        chk("R5 step4 blocked", 32'(blk_s), 32'd1);
        chk("R3 pulse", 32'(pulse_s), 32'd1);
        chk("R2 R9 cfg stored", 32'(cfg_s), 32'(expv));
        @(negedge clk);
        chk("R3 pulse single", 32'(sw_load), 32'd0);
        exp_cfg = expv;
    endtask

    task automatic t_read;
        acc(TOPA, 1'b0, '0);
        acc(TOPA, 1'b0, '0);
        acc(TOPA, 1'b1, 16'h0000);
        acc(TOPA, 1'b0, '0);
        chk("R4 override", 32'(ovr_s), 32'd1);
        chk("R4 data", 32'(rd_s), 32'(exp_cfg));
        chk("R3 no pulse on read", 32'(pulse_s), 32'd0);
        chk("R4 cfg unchanged", 32'(cfg_s), 32'(exp_cfg));
    endtask

    task automatic t_mismatch;
        acc(OTHA, 1'b1, 16'h5555); chk("R5 other write", 32'(blk_s), 32'd0);
        acc(TOPA, 1'b1, 16'h0000); chk("R8 step1 write unblocked", 32'(blk_s), 32'd0);
        acc(TOPA, 1'b0, '0);
        acc(TOPA, 1'b0, '0);
        acc(TOPA, 1'b1, 16'h1234); chk("R5 nonzero step3", 32'(blk_s), 32'd0);
        acc(TOPA, 1'b0, '0); chk("R8 after nonzero step3", 32'(ovr_s), 32'd0);
        acc(TOPA, 1'b0, '0);
        acc(OTHA, 1'b0, '0);
        acc(TOPA, 1'b1, 16'h0000); chk("R8 foreign read resets", 32'(blk_s), 32'd0);
    endtask

    task automatic t_cancel;
        acc(OTHA, 1'b0, '0);
        acc(TOPA, 1'b0, '0);
        acc(TOPA, 1'b0, '0);
        acc(TOPA, 1'b0, '0);
        acc(TOPA, 1'b1, 16'h0000); chk("R6 cancelled step3", 32'(blk_s), 32'd0);
        acc(TOPA, 1'b1, 16'h00E2); chk("R6 cancelled step4", 32'(blk_s), 32'd0);
        chk("R6 cfg kept", 32'(cfg_s), 32'(exp_cfg));
        acc(OTHA, 1'b1, 16'h0001);
        acc(TOPA, 1'b0, '0);
        acc(TOPA, 1'b0, '0);
        acc(TOPA, 1'b1, 16'h0000); chk("R7 still cancelled", 32'(blk_s), 32'd0);
        acc(TOPA, 1'b0, '0); chk("R7 no override", 32'(ovr_s), 32'd0);
        acc(OTHA, 1'b0, '0);
        acc(TOPA, 1'b0, '0);
        acc(TOPA, 1'b0, '0);
        acc(TOPA, 1'b1, 16'h0000); chk("R6 resumed step3", 32'(blk_s), 32'd1);
        acc(TOPA, 1'b0, '0); chk("R6 resumed read", 32'(ovr_s), 32'd1);
        chk("R6 resumed data", 32'(rd_s), 32'(exp_cfg));
    endtask

    initial begin : watchdog
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        exp_cfg = 16'h0010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read();
        t_load(16'hFFEF, 16'h00F7);
        t_read();
        t_mismatch();
        t_cancel();
        t_load(16'h0062, 16'h0072);
        t_read();
        t_load(16'h0005, 16'h0015);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule